// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter with Alarms

This block keeps a 64-bit time-of-day value in nanoseconds for stamping packets. The rate is trimmed without changing the reference clock. A 32-bit addend is summed into a 32-bit phase accumulator on every clock. Each carry out of that sum advances the time by a programmed number of nanoseconds. Software sets the long-term rate through the addend and the step size through the increment.

Two one-shot alarms, a periodic one-cycle pulse and a divide-by-N clock all run from the same time base. A time load realigns the pulse and the divided clock to the load instant. Separate transmit and receive strobes freeze the current time into holding registers, and each register keeps its value until software acknowledges it.

Top module: `ns_timebase`

## Requirements
- R1: After reset, time_now, both stamps, both stamp valids, alarm_flag, pulse_out and div_clk are all zero. The addend and increment are zero, and the divider value is 2.
- R2: On every clock without a time load, the accumulator becomes (accumulator + addend) mod 2^32. When that sum carries out of bit 31, time_now advances by the increment, wrapping modulo 2^64. Writes to the addend and increment apply from the next clock.
- R3: A time load replaces all 64 bits of time_now on the next clock, clears the accumulator, and overrides any increment due in that cycle.
- R4: An armed alarm whose target is less than or equal to time_now (unsigned) sets its alarm_flag bit on the next clock and disarms itself. It does not fire again until its target is written again.
- R5: Writing an alarm target arms that alarm. Driving a 1 on an alarm_clr bit clears that flag on the next clock. If a fire and a clear fall in the same cycle, the flag is set.
- R6: With period P nonzero, pulse_out is high for one clock every P clocks. The first pulse comes P clocks after a time load or a period write, and either event restarts the count. P = 0 keeps pulse_out low.
- R7: The divider counts 0 to N-1, and N values below 2 act as 2. div_clk is low while the count is below floor(N/2) and high otherwise. A time load or a divider write returns the count to 0.
- R8: A strobe latches the time_now of that cycle, before any update at that edge, and sets the matching valid. While valid is set, strobes are ignored unless the acknowledge is high in the same cycle. An acknowledge alone clears valid. Transmit and receive are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_we | input | 1 | Load time_wdata into the counter |
| time_wdata | input | 64 | New time in ns |
| addend_we | input | 1 | Write the rate addend |
| addend_wdata | input | 32 | Addend value |
| incr_we | input | 1 | Write the step size |
| incr_wdata | input | 8 | ns added per accumulator carry |
| alarm_we | input | 2 | Per-alarm target write (arms it) |
| alarm_wdata | input | 64 | Alarm target time |
| alarm_clr | input | 2 | Write-1-to-clear for alarm_flag |
| period_we | input | 1 | Write pulse period |
| period_wdata | input | 32 | Pulse period in clocks |
| divn_we | input | 1 | Write divider N |
| divn_wdata | input | 16 | Divide ratio N |
| tx_strobe | input | 1 | Transmit capture request |
| tx_ack | input | 1 | Transmit stamp read |
| rx_strobe | input | 1 | Receive capture request |
| rx_ack | input | 1 | Receive stamp read |
| time_now | output | 64 | Current time in ns |
| tx_stamp | output | 64 | Held transmit timestamp |
| tx_valid | output | 1 | Transmit stamp held |
| rx_stamp | output | 64 | Held receive timestamp |
| rx_valid | output | 1 | Receive stamp held |
| alarm_flag | output | 2 | Sticky alarm flags |
| pulse_out | output | 1 | Periodic one-cycle pulse |
| div_clk | output | 1 | Divided clock |

## Verification
Two pairs of events can land on the same clock edge. A time load can coincide with a capture strobe, and the stamp must then hold the pre-load time. An alarm can fire in the same cycle that software writes 1 to clear its flag, and the flag must then end up set. Both collisions are built by hand, and the random phase produces more of them. There, targets are drawn a few hundred ns ahead of the model's time, and clears, strobes and loads arrive often. Every cycle, all outputs are compared with a model driven only by the requirements.

// File: rtl/ns_timebase.sv
module ns_timebase #(
  parameter int TW = 64,
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int PW = 32,
  parameter int DW = 16,
  parameter int NA = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          time_we,
  input  logic [TW-1:0] time_wdata,
  input  logic          addend_we,
  input  logic [AW-1:0] addend_wdata,
  input  logic          incr_we,
  input  logic [IW-1:0] incr_wdata,
  input  logic [NA-1:0] alarm_we,
  input  logic [TW-1:0] alarm_wdata,
  input  logic [NA-1:0] alarm_clr,
  input  logic          period_we,
  input  logic [PW-1:0] period_wdata,
  input  logic          divn_we,
  input  logic [DW-1:0] divn_wdata,
  input  logic          tx_strobe,
  input  logic          tx_ack,
  input  logic          rx_strobe,
  input  logic          rx_ack,
  output logic [TW-1:0] time_now,
  output logic [TW-1:0] tx_stamp,
  output logic          tx_valid,
  output logic [TW-1:0] rx_stamp,
  output logic          rx_valid,
  output logic [NA-1:0] alarm_flag,
  output logic          pulse_out,
  output logic          div_clk
);

  logic [AW-1:0] acc, addend;
  logic [IW-1:0] incr;
  logic [AW:0]   acc_sum;
  assign acc_sum = {1'b0, acc} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_now <= '0;
      acc      <= '0;
      addend   <= '0;
      incr     <= '0;
    end else begin
      if (time_we) begin
        time_now <= time_wdata;
        acc      <= '0;
      end else begin
        acc <= acc_sum[AW-1:0];
        if (acc_sum[AW]) time_now <= time_now + TW'(incr);
      end
      if (addend_we) addend <= addend_wdata;
      if (incr_we)   incr   <= incr_wdata;
    end
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    time_we |=> time_now == $past(time_wdata));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !time_we |=> (time_now == $past(time_now)) ||
                 (time_now == $past(time_now) + TW'($past(incr))));

  // Alarms
  for (genvar g = 0; g < NA; g++) begin : g_alarm
    logic [TW-1:0] tgt;
    logic          armed, flag, hit;
    assign hit = armed && (time_now >= tgt);
    assign alarm_flag[g] = flag;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt   <= '0;
        armed <= 1'b0;
        flag  <= 1'b0;
      end else begin
        if (alarm_we[g]) begin
          tgt   <= alarm_wdata;
          armed <= 1'b1;
        end else if (hit) armed <= 1'b0;
        if (hit)               flag <= 1'b1;
        else if (alarm_clr[g]) flag <= 1'b0;
      end
    end

    assert_oneshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !alarm_we[g]) |=> (flag && !armed));
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_clr[g] && !hit) |=> !flag);
  end

  // Periodic pulse
  logic [PW-1:0] pper, pcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pper <= '0; pcnt <= '0; pulse_out <= 1'b0;
    end else if (time_we) begin
      pcnt <= '0; pulse_out <= 1'b0;
    end else if (period_we) begin
      pper <= period_wdata; pcnt <= '0; pulse_out <= 1'b0;
    end else if (pper != '0 && pcnt == pper - 1'b1) begin
      pcnt <= '0; pulse_out <= 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1; pulse_out <= 1'b0;
    end
  end

  assert_pulse_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> pper != '0);

  // Divide-by-N clock
  logic [DW-1:0] divn, dcnt, n_eff;
  assign n_eff   = (divn < DW'(2)) ? DW'(2) : divn;
  assign div_clk = dcnt >= (n_eff >> 1);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divn <= DW'(2); dcnt <= '0;
    end else begin
      if (divn_we) divn <= divn_wdata;
      if (time_we || divn_we)       dcnt <= '0;
      else if (dcnt >= n_eff - 1'b1) dcnt <= '0;
      else                           dcnt <= dcnt + 1'b1;
    end
  end

  assert_div_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt < n_eff);

  // Timestamp capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_stamp <= '0; tx_valid <= 1'b0;
      rx_stamp <= '0; rx_valid <= 1'b0;
    end else begin
      if (tx_strobe && (!tx_valid || tx_ack)) begin
        tx_stamp <= time_now; tx_valid <= 1'b1;
      end else if (tx_ack) tx_valid <= 1'b0;
      if (rx_strobe && (!rx_valid || rx_ack)) begin
        rx_stamp <= time_now; rx_valid <= 1'b1;
      end else if (rx_ack) rx_valid <= 1'b0;
    end
  end

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ack) |=> $stable(tx_stamp));
  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack) |=> $stable(rx_stamp));

endmodule

// File: tb/ns_timebase_tb.sv
module ns_timebase_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        time_we, addend_we, incr_we, period_we, divn_we;
  logic [63:0] time_wdata, alarm_wdata;
  logic [31:0] addend_wdata, period_wdata;
  logic [7:0]  incr_wdata;
  logic [15:0] divn_wdata;
  logic [1:0]  alarm_we, alarm_clr;
  logic        tx_strobe, tx_ack, rx_strobe, rx_ack;
  logic [63:0] time_now, tx_stamp, rx_stamp;
  logic        tx_valid, rx_valid, pulse_out, div_clk;
  logic [1:0]  alarm_flag;

  ns_timebase dut_i (.*);

  int vectors = 0, fails = 0;

  // reference model state
  logic [63:0] m_time, m_txs, m_rxs;
  logic [31:0] m_acc, m_add, m_pper, m_pcnt;
  logic [7:0]  m_inc;
  logic [15:0] m_dn, m_dcnt;
  logic        m_txv, m_rxv, m_pulse;
  logic [63:0] m_tgt [2];
  logic [1:0]  m_arm, m_flag;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] neff(logic [15:0] n);
    return (n < 16'd2) ? 16'd2 : n;
  endfunction

  task automatic model_reset();
    m_time = 0; m_acc = 0; m_add = 0; m_inc = 0;
    m_txs = 0; m_rxs = 0; m_txv = 0; m_rxv = 0;
    m_tgt[0] = 0; m_tgt[1] = 0; m_arm = 0; m_flag = 0;
    m_pper = 0; m_pcnt = 0; m_pulse = 0; m_dn = 16'd2; m_dcnt = 0;
  endtask

  task automatic model_step();
    logic [32:0] s;
    logic        hit;
    s = {1'b0, m_acc} + {1'b0, m_add};
    if (tx_strobe && (!m_txv || tx_ack)) begin m_txs = m_time; m_txv = 1; end
    else if (tx_ack) m_txv = 0;
    if (rx_strobe && (!m_rxv || rx_ack)) begin m_rxs = m_time; m_rxv = 1; end
    else if (rx_ack) m_rxv = 0;
    for (int i = 0; i < 2; i++) begin
      hit = m_arm[i] && (m_time >= m_tgt[i]);
      if (alarm_we[i]) begin m_tgt[i] = alarm_wdata; m_arm[i] = 1; end
      else if (hit) m_arm[i] = 0;
      if (hit) m_flag[i] = 1; else if (alarm_clr[i]) m_flag[i] = 0;
    end
    if (time_we) begin m_pcnt = 0; m_pulse = 0; end
    else if (period_we) begin m_pper = period_wdata; m_pcnt = 0; m_pulse = 0; end
    else if (m_pper != 0 && m_pcnt == m_pper - 1) begin m_pcnt = 0; m_pulse = 1; end
    else begin m_pcnt = m_pcnt + 1; m_pulse = 0; end
    if (time_we || divn_we) m_dcnt = 0;
    else if (m_dcnt >= neff(m_dn) - 1) m_dcnt = 0;
    else m_dcnt = m_dcnt + 1;
    if (divn_we) m_dn = divn_wdata;
    if (time_we) begin m_time = time_wdata; m_acc = 0; end
    else begin m_acc = s[31:0]; if (s[32]) m_time = m_time + 64'(m_inc); end
    if (addend_we) m_add = addend_wdata;
    if (incr_we)   m_inc = incr_wdata;
  endtask

  task automatic compare_all();
    chk("R2/R3 time_now", time_now, m_time);
    chk("R8 tx_stamp", tx_stamp, m_txs);
    chk("R8 tx_valid", 64'(tx_valid), 64'(m_txv));
    chk("R8 rx_stamp", rx_stamp, m_rxs);
    chk("R8 rx_valid", 64'(rx_valid), 64'(m_rxv));
    chk("R4/R5 alarm_flag", 64'(alarm_flag), 64'(m_flag));
    chk("R6 pulse_out", 64'(pulse_out), 64'(m_pulse));
    chk("R7 div_clk", 64'(div_clk), 64'(m_dcnt >= (neff(m_dn) >> 1)));
  endtask

  task automatic idle();
    time_we = 0; addend_we = 0; incr_we = 0; period_we = 0; divn_we = 0;
    alarm_we = 0; alarm_clr = 0;
    tx_strobe = 0; tx_ack = 0; rx_strobe = 0; rx_ack = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare_all();
    idle();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    time_wdata = 0; alarm_wdata = 0; addend_wdata = 0; incr_wdata = 0;
    period_wdata = 0; divn_wdata = 0;
    rst_n = 0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 time_now", time_now, 64'd0);
    chk("R1 valids", 64'({tx_valid, rx_valid}), 64'd0);
    chk("R1 stamps", tx_stamp | rx_stamp, 64'd0);
    chk("R1 flags/pulse/div", 64'({alarm_flag, pulse_out, div_clk}), 64'd0);
    rst_n = 1;

    // R2: half-rate carries, 8 ns step
    addend_we = 1; addend_wdata = 32'h8000_0000; incr_we = 1; incr_wdata = 8'd8;
    cyc(); run(10);
    // R3: load near wrap, increments wrap through zero
    time_we = 1; time_wdata = 64'hFFFF_FFFF_FFFF_FFF0; cyc(); run(10);
    // R3 + R8: load collides with capture strobe
    time_we = 1; time_wdata = 64'd1000; tx_strobe = 1; rx_strobe = 1; cyc(); run(2);
    // R8: further strobes ignored while held, then ack+strobe recaptures
    tx_strobe = 1; cyc(); run(3);
    tx_strobe = 1; tx_ack = 1; cyc();
    rx_ack = 1; cyc(); run(2);
    // R4: two alarms ahead
    alarm_we = 2'b11; alarm_wdata = m_time + 64'd24; cyc(); run(12);
    // R4: alarm stays quiet after clear until rewritten
    alarm_clr = 2'b11; cyc(); run(6);
    // R5: fire and clear in the same cycle -> flag set
    alarm_we = 2'b01; alarm_wdata = m_time; cyc();
    alarm_clr = 2'b01; cyc(); run(2);
    // R6/R7: pulse period 5, divider 5, then N=0 and N=1 act as 2
    period_we = 1; period_wdata = 32'd5; divn_we = 1; divn_wdata = 16'd5; cyc(); run(20);
    divn_we = 1; divn_wdata = 16'd0; cyc(); run(6);
    divn_we = 1; divn_wdata = 16'd1; cyc(); run(6);
    divn_we = 1; divn_wdata = 16'd7; cyc(); run(5);
    time_we = 1; time_wdata = 64'd5000; cyc(); run(12);
    period_we = 1; period_wdata = 32'd0; cyc(); run(8);

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      time_we   = ($urandom_range(0, 63) == 0);
      time_wdata = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) != 0) time_wdata = 64'($urandom_range(0, 100000));
      addend_we = ($urandom_range(0, 31) == 0); addend_wdata = $urandom();
      incr_we   = ($urandom_range(0, 31) == 0); incr_wdata = 8'($urandom_range(1, 255));
      alarm_we  = {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
      alarm_wdata = m_time + 64'($urandom_range(0, 300));
      alarm_clr = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
      period_we = ($urandom_range(0, 63) == 0); period_wdata = $urandom_range(0, 12);
      divn_we   = ($urandom_range(0, 63) == 0); divn_wdata = 16'($urandom_range(0, 9));
      tx_strobe = ($urandom_range(0, 3) == 0); tx_ack = ($urandom_range(0, 3) == 0);
      rx_strobe = ($urandom_range(0, 3) == 0); rx_ack = ($urandom_range(0, 3) == 0);
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule